// File: doc/BRIEF.md
# Manchester configuration dump transmitter

In test mode this block sends a selected address window of configuration memory, one byte after another, on a single current-sink output. A synchronized test-request level enters test mode only while mode bit 0 is set. The window and its source are chosen at entry. The source is either the EEPROM image, which is re-read for every byte, or the RAM image. Each byte is read through a memory port with a one-cycle latency and latched before its frame starts. The frame is then sent as Manchester-coded half-bit slots: a start bit of one, eight data bits with the MSB first, and an idle pause with the sink off. After the last address the dump starts again from the first address for as long as the request stays high.

The slot length comes from a system-clock divider. It has one terminal count for the fast rate and one for the slow rate, and the rate is latched at entry. When the request falls, test mode ends at once and any frame in progress is cut off with the sink off. At exit the block pulses a configuration reload request if the live mode field is nonzero. The reload covers the low configuration window, addresses 0x00 to 0x21. With mode 00 at exit, operation resumes with no reload.

Top module: `cfg_dump_tx`

## Requirements
- R1: Test mode is entered only in a cycle where `test_req_i` is 1 and `mode_i[0]` is 1. With mode 10 or 00 the request has no effect: no read is issued and the sink stays off.
- R2: The window is latched at entry. Mode 01 with `mem_sel_i`=0 sends addresses 0x1B..0x7F from EEPROM. Mode 01 with `mem_sel_i`=1 sends 0x3B..0x43 from RAM. Mode 11 sends EEPROM 0x00..0x7F. `rd_src_o` is 0 for EEPROM and 1 for RAM.
- R3: Each frame is 9 bits, a start bit of 1 and then data bits 7 down to 0, followed by PAUSE_SLOTS slots with the sink off. Frames follow each other with two extra sink-off cycles for the read between them.
- R4: Each bit takes two slots. A one is sent as sink on then off, and a zero as sink off then on.
- R5: A slot lasts FAST_DIV clock cycles if `fast_i` was 1 at entry and SLOW_DIV cycles otherwise. A change of `fast_i` during test mode has no effect.
- R6: After the last address of the window, the next byte read is the first address of the window.
- R7: The first cycle after `test_req_i` is sampled low in test mode has the sink off and no read, and the frame does not resume.
- R8: One cycle after test mode is left, `reload_o` pulses for one cycle if `mode_i` was nonzero in the exit cycle. It stays 0 if `mode_i` was 00.
- R9: `rd_en_o` is high for exactly one cycle per byte, one cycle after entry or after the end of the previous frame. The first slot starts two cycles after the read. Out of reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_req_i | input | 1 | Synchronized high-threshold test request |
| mode_i | input | 2 | Test mode field |
| mem_sel_i | input | 1 | Source select at entry: 0 EEPROM, 1 RAM |
| fast_i | input | 1 | Slot rate select at entry: 1 fast, 0 slow |
| rd_en_o | output | 1 | Memory read strobe |
| rd_src_o | output | 1 | Memory source: 0 EEPROM, 1 RAM |
| rd_addr_o | output | 7 | Memory read address |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| sink_on_o | output | 1 | Current sink enable |
| reload_o | output | 1 | One-cycle configuration reload request |

## Verification
Test-mode entry is visible one cycle after the request is sampled, as the read strobe. The first slot follows two cycles after that read. The sink turning off and the reload pulse are both due in the cycle after the request is sampled low. The bench advances a behavioural model on each rising edge using the same inputs the design sees, and it compares every output on the falling edge, so each result is checked in the cycle it is due. Directed checks cover the ignored modes, the window wrap, the latched rate and both exit cases.

// File: rtl/cfg_dump_pkg.sv
package cfg_dump_pkg;
  localparam int unsigned AW = 7;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SEND
  } dump_state_e;

  localparam logic [AW-1:0] EE_PART_FIRST = 7'h1B;
  localparam logic [AW-1:0] EE_FULL_FIRST = 7'h00;
  localparam logic [AW-1:0] EE_LAST       = 7'h7F;
  localparam logic [AW-1:0] RAM_FIRST     = 7'h3B;
  localparam logic [AW-1:0] RAM_LAST      = 7'h43;

  localparam logic SRC_EE  = 1'b0;
  localparam logic SRC_RAM = 1'b1;
endpackage

// File: rtl/cfg_dump_range.sv
module cfg_dump_range
  import cfg_dump_pkg::*;
(
  input  logic [1:0]    mode_i,
  input  logic          mem_sel_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] last_o,
  output logic          src_o
);
  always_comb begin
    first_o = EE_PART_FIRST;
    last_o  = EE_LAST;
    src_o   = SRC_EE;
    if (mode_i == 2'b11) begin
      first_o = EE_FULL_FIRST;
    end else if (mem_sel_i) begin
      first_o = RAM_FIRST;
      last_o  = RAM_LAST;
      src_o   = SRC_RAM;
    end
  end
endmodule

// File: rtl/cfg_dump_slot_timer.sv
module cfg_dump_slot_timer #(
  parameter int unsigned FAST_DIV = 98,
  parameter int unsigned SLOW_DIV = 391
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned MAXDIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int unsigned CW     = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  assign term   = fast_i ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_dump_framer.sv
module cfg_dump_framer
  import cfg_dump_pkg::*;
#(
  parameter int unsigned PAUSE_SLOTS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [DW-1:0] data_i,
  output logic          sink_o,
  output logic          done_o
);
  localparam int unsigned FRAME_BITS = DW + 1;
  localparam int unsigned DATA_SLOTS = 2 * FRAME_BITS;
  localparam int unsigned TOTAL      = DATA_SLOTS + PAUSE_SLOTS;
  localparam int unsigned SW         = $clog2(TOTAL);

  logic [FRAME_BITS-1:0] frm_q;
  logic [SW-1:0]         slot_q;
  logic                  in_data;
  logic                  cur_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frm_q  <= '0;
      slot_q <= '0;
    end else if (load_i) begin
      frm_q  <= {1'b1, data_i};
      slot_q <= '0;
    end else if (run_i && tick_i && !done_o) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  always_comb begin
    in_data = (int'(slot_q) < DATA_SLOTS);
    cur_bit = 1'b0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      if (int'(slot_q >> 1) == FRAME_BITS - 1 - i) cur_bit = frm_q[i];
    end
  end

  // one: on then off; zero: off then on
  assign sink_o = run_i && in_data && (cur_bit ^ slot_q[0]);
  assign done_o = run_i && tick_i && (int'(slot_q) == TOTAL - 1);
endmodule

// File: rtl/cfg_dump_tx.sv
module cfg_dump_tx
  import cfg_dump_pkg::*;
#(
  parameter int unsigned FAST_DIV    = 98,
  parameter int unsigned SLOW_DIV    = 391,
  parameter int unsigned PAUSE_SLOTS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          test_req_i,
  input  logic [1:0]    mode_i,
  input  logic          mem_sel_i,
  input  logic          fast_i,
  output logic          rd_en_o,
  output logic          rd_src_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          sink_on_o,
  output logic          reload_o
);
  dump_state_e   state_q;
  logic [AW-1:0] addr_q, first_q, last_q;
  logic          src_q, fast_q, reload_q;
  logic [AW-1:0] sel_first, sel_last;
  logic          sel_src;
  logic          active, sending, tick, done;

  assign active  = (state_q != ST_IDLE);
  assign sending = (state_q == ST_SEND);

  cfg_dump_range u_range (
    .mode_i   (mode_i),
    .mem_sel_i(mem_sel_i),
    .first_o  (sel_first),
    .last_o   (sel_last),
    .src_o    (sel_src)
  );

  cfg_dump_slot_timer #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (sending),
    .fast_i(fast_q),
    .tick_o(tick)
  );

  cfg_dump_framer #(
    .PAUSE_SLOTS(PAUSE_SLOTS)
  ) u_framer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(state_q == ST_LOAD),
    .run_i (sending),
    .tick_i(tick),
    .data_i(rd_data_i),
    .sink_o(sink_on_o),
    .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      first_q  <= '0;
      last_q   <= '0;
      src_q    <= SRC_EE;
      fast_q   <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      if (!active) begin
        if (test_req_i && mode_i[0]) begin
          state_q <= ST_FETCH;
          addr_q  <= sel_first;
          first_q <= sel_first;
          last_q  <= sel_last;
          src_q   <= sel_src;
          fast_q  <= fast_i;
        end
      end else if (!test_req_i) begin
        state_q  <= ST_IDLE;
        reload_q <= (mode_i != 2'b00);
      end else begin
        unique case (state_q)
          ST_FETCH: state_q <= ST_LOAD;
          ST_LOAD:  state_q <= ST_SEND;
          ST_SEND: if (done) begin
            state_q <= ST_FETCH;
            addr_q  <= (addr_q == last_q) ? first_q : addr_q + 1'b1;
          end
          default:  state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_en_o   = (state_q == ST_FETCH);
  assign rd_addr_o = addr_q;
  assign rd_src_o  = src_q;
  assign reload_o  = reload_q;
endmodule

// File: rtl/cfg_dump_tx_chk.sv
module cfg_dump_tx_chk
  import cfg_dump_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          test_req_i,
  input logic [1:0]    mode_i,
  input logic          active_i,
  input logic          rd_en_o,
  input logic          rd_src_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          sink_on_o,
  input logic          reload_o
);
  assert_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> ($past(test_req_i) && $past(mode_i[0])));

  assert_ram_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && rd_src_o) |-> (rd_addr_o >= RAM_FIRST && rd_addr_o <= RAM_LAST));

  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !test_req_i) |=> (!sink_on_o && !rd_en_o && !active_i));

  assert_reload_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> ($past(active_i) && !$past(test_req_i) && ($past(mode_i) != 2'b00)));

  assert_reload_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !reload_o);

  assert_rd_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);

  assert_no_sink_at_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> !sink_on_o);
endmodule

bind cfg_dump_tx cfg_dump_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .test_req_i(test_req_i),
  .mode_i    (mode_i),
  .active_i  (active),
  .rd_en_o   (rd_en_o),
  .rd_src_o  (rd_src_o),
  .rd_addr_o (rd_addr_o),
  .sink_on_o (sink_on_o),
  .reload_o  (reload_o)
);

// File: tb/cfg_dump_tx_tb_top.sv
`timescale 1ns/1ps
module cfg_dump_tx_tb_top;
  localparam int FD = 3;
  localparam int SD = 5;
  localparam int PS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       sel = 1'b0;
  logic       fast = 1'b0;
  logic       rd_en, rd_src, sink, reload;
  logic [6:0] rd_addr;
  logic [7:0] rd_data = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_dump_tx #(.FAST_DIV(FD), .SLOW_DIV(SD), .PAUSE_SLOTS(PS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .test_req_i(req), .mode_i(mode),
    .mem_sel_i(sel), .fast_i(fast), .rd_en_o(rd_en), .rd_src_o(rd_src),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .sink_on_o(sink), .reload_o(reload)
  );

  function automatic logic [7:0] mem_byte(input int src, input int a);
    if (src != 0) return 8'(a ^ 8'hC3);
    return 8'(a * 37 + 11);
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_byte(int'(rd_src), int'(rd_addr));

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference
  int m_act = 0, m_t = 0, m_addr = 0, m_first = 0, m_last = 0, m_src = 0, m_T = SD;
  bit m_reload = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_reload = 0;
    end else begin
      m_reload = 0;
      if (m_act == 0) begin
        if (req && mode[0]) begin
          m_act = 1; m_t = 0;
          if (mode == 2'b11) begin m_first = 0; m_last = 127; m_src = 0; end
          else if (sel) begin m_first = 59; m_last = 67; m_src = 1; end
          else begin m_first = 27; m_last = 127; m_src = 0; end
          m_T = fast ? FD : SD;
          m_addr = m_first;
        end
      end else if (!req) begin
        m_act = 0; m_reload = (mode != 2'b00);
      end else begin
        m_t++;
        if (m_t == 2 + (18 + PS) * m_T) begin
          m_t = 0;
          m_addr = (m_addr == m_last) ? m_first : m_addr + 1;
        end
      end
    end
  end

  int reloads = 0, reads = 0, wraps = 0, prev_ram = -1;
  int first_addr = -1, first_src = -1;

  always @(negedge clk) begin
    int s, exp_sink;
    logic [8:0] fb;
    string tag;
    if (rst_n && !done) begin
      exp_sink = 0;
      tag = "R7";
      if (m_act != 0) begin
        if (m_t < 2) tag = "R9";
        else begin
          s = (m_t - 2) / m_T;
          if (s >= 18) tag = "R3";
          else begin
            tag = "R4/R5";
            fb = {1'b1, mem_byte(m_src, m_addr)};
            exp_sink = (fb[8 - s / 2] ^ s[0]) ? 1 : 0;
          end
        end
      end
      chk({"sink ", tag}, int'(sink), exp_sink);
      chk("rd_en R9", int'(rd_en), (m_act != 0 && m_t == 0) ? 1 : 0);
      chk("reload R8", int'(reload), int'(m_reload));
      if (rd_en) begin
        chk("rd_addr R2/R6", int'(rd_addr), m_addr);
        chk("rd_src R2", int'(rd_src), m_src);
        reads++;
        if (first_addr < 0) begin first_addr = int'(rd_addr); first_src = int'(rd_src); end
        if (rd_src) begin
          if (prev_ram == 8'h43) begin chk("wrap R6", int'(rd_addr), 8'h3B); wraps++; end
          prev_ram = int'(rd_addr);
        end
      end
      if (reload) reloads++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    done = 1;
    summary();
  end

  initial begin
    cyc(3);
    chk("reset sink R9", int'(sink), 0);
    chk("reset rd_en R9", int'(rd_en), 0);
    chk("reset reload R9", int'(reload), 0);
    rst_n = 1'b1;
    cyc(2);

    // R1: mode 10 never enters
    mode = 2'b10; req = 1'b1; reads = 0;
    cyc(60);
    chk("no entry mode 10 R1", reads, 0);
    req = 1'b0; cyc(3);

    // RAM window, fast, wraps; fast_i changes mid-run (R5 latched)
    mode = 2'b01; sel = 1'b1; fast = 1'b1; req = 1'b1; reloads = 0; wraps = 0; prev_ram = -1;
    first_addr = -1;
    cyc(300);
    fast = 1'b0;
    cyc(700);
    chk("first ram addr R2", first_addr, 8'h3B);
    chk("first ram src R2", first_src, 1);
    chk("window wrapped R6", (wraps > 0) ? 1 : 0, 1);
    cyc(23);
    req = 1'b0; // mid-frame abort, mode 01
    cyc(4);
    chk("reload on exit R8", reloads, 1);
    chk("sink off after abort R7", int'(sink), 0);

    // EEPROM window, slow; mode to 00 before exit
    mode = 2'b01; sel = 1'b0; fast = 1'b0; req = 1'b1; reloads = 0; first_addr = -1;
    cyc(350);
    chk("first ee addr R2", first_addr, 8'h1B);
    mode = 2'b00; // no effect on running window
    cyc(40);
    req = 1'b0;
    cyc(4);
    chk("no reload with mode 00 R8", reloads, 0);

    // full EEPROM, fast
    mode = 2'b11; sel = 1'b1; fast = 1'b1; req = 1'b1; first_addr = -1; reloads = 0;
    cyc(200);
    chk("full ee first addr R2", first_addr, 0);
    chk("full ee src R2", first_src, 0);
    req = 1'b0;
    cyc(4);
    chk("reload mode 11 R8", reloads, 1);

    done = 1;
    summary();
  end
endmodule